// File: doc/BRIEF.md
# LCD Controller Register and Interrupt Unit

This block is the software-visible register set of a colour LCD controller. It sits on a plain 32-bit word-addressed register bus inside a 4 KB window. Through that bus, software programs four timing words, an upper and a lower frame base address, a control word and a four-bit interrupt mask. It also reads back raw and masked interrupt status, clears status bits, and reads a fixed identification sequence. From the first two timing words the block derives the active column and row counts, and from the control word it derives the display-enable level and the pixel-depth code, for the pixel engine that follows.

A frame counter with a period of `TICK_CYCLES` clocks stands in for vertical blanking. While the display is enabled, every frame tick raises the next-base and vertical-compare status bits. The interrupt output is a level that stays high while any unmasked status bit is set. A two-bit variant input selects the register layout and the identification sequence. Every bus write produces a one-cycle invalidate pulse, so that downstream fetch logic can reload the frame.

The bus uses word addresses: `word_addr_i` equals the byte offset divided by four. Read data is registered: it appears on `rdata_o` one clock after the cycle in which `rd_i` is high, and holds until the next read.

Top module: `lcd_reg_irq`

## Requirements
- R1: While `rst_ni` is low and after reset, all stored registers are 0, `irq_o`, `invalidate_o` and `enabled_o` are 0, `bpp_o` is 0, `cols_o` is 16 and `rows_o` is 1.
- R2: With `variant_i`=0, byte offsets 0x00, 0x04, 0x08 and 0x0C hold timing words 0 to 3 (32 bits each), 0x10 holds the upper base, 0x14 the lower base, 0x18 the interrupt mask (bits 3:0, upper bits read 0) and 0x1C the 32-bit control word. A read returns its value on `rdata_o` in the next cycle, and `rdata_o` holds while no read is made.
- R3: With `variant_i` nonzero, byte offset 0x18 accesses the control word and 0x1C accesses the interrupt mask.
- R4: `cols_o` equals ((timing0 AND 0xFC) + 4) × 4 and `rows_o` equals (timing1 AND 0x3FF) + 1. No other bits affect them.
- R5: `enabled_o` is 1 exactly when control bit 0 and control bit 11 are both 1. `bpp_o` equals control bits 3:1.
- R6: While enabled, raw status bits 2 and 3 are set TICK_CYCLES clocks after the control write that enabled the display, and every TICK_CYCLES clocks after that. Any control write that leaves the display enabled restarts this count. While disabled, no status bit is set.
- R7: A write to byte offset 0x28 clears each raw status bit whose data bit is 1. A frame tick in the same cycle wins over the clear.
- R8: Byte offset 0x20 reads the raw status (bits 3:0), 0x24 reads raw AND mask, and `irq_o` is 1 exactly when raw AND mask is nonzero.
- R9: Byte offsets 0xFE0 to 0xFFC return one identification byte per word, in this order: 0x10,0x11,0x04,0x00,0x0D,0xF0,0x05,0xB1 when `variant_i` is 0 or 1, and 0x11,0x11,0x24,0x00,0x0D,0xF0,0x05,0xB1 when `variant_i` is 2 or 3.
- R10: Byte offset 0x2C reads the upper base and 0x30 reads the lower base.
- R11: Reads of offsets with no register return 0. Writes to them, and writes to 0x20 and 0x24, change no register.
- R12: `invalidate_o` is high for exactly the one cycle after each cycle with `wr_i` high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| variant_i | input | 2 | Layout and identification select |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| word_addr_i | input | 10 | Word address (byte offset / 4) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt |
| invalidate_o | output | 1 | One-cycle pulse after each write |
| enabled_o | output | 1 | Display enabled |
| bpp_o | output | 3 | Pixel depth code |
| cols_o | output | 11 | Active columns |
| rows_o | output | 11 | Active rows |

## Verification
The assertions assume that `wr_i` and `rd_i` are never high in the same cycle. They also assume that `variant_i` changes only between accesses and that all inputs are driven to known values from time zero. The stimulus issues one access at a time from tasks that change inputs on the falling edge. It changes the variant only while the bus is idle. The frame-tick checks are timed against the bench's own count of edges from the enabling write, including one clear that lands on the tick edge itself.

// File: rtl/lcd_reg_pkg.sv
package lcd_reg_pkg;
  localparam int DATA_W     = 32;
  localparam int WORD_AW    = 10;
  localparam int STAT_W     = 4;
  localparam int NUM_TIMING = 4;
  localparam int COL_W      = 11;
  localparam int ROW_W      = 11;
  localparam int BPP_W      = 3;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_PWR_BIT = 11;
  localparam int ST_NEXT_BASE = 2;
  localparam int ST_VCOMP     = 3;

  localparam logic [WORD_AW-1:0] W_UPBASE = 10'd4;
  localparam logic [WORD_AW-1:0] W_LPBASE = 10'd5;
  localparam logic [WORD_AW-1:0] W_SLOT_A = 10'd6;
  localparam logic [WORD_AW-1:0] W_SLOT_B = 10'd7;
  localparam logic [WORD_AW-1:0] W_RAW    = 10'd8;
  localparam logic [WORD_AW-1:0] W_MSK_ST = 10'd9;
  localparam logic [WORD_AW-1:0] W_CLEAR  = 10'd10;
  localparam logic [WORD_AW-1:0] W_UPCUR  = 10'd11;
  localparam logic [WORD_AW-1:0] W_LPCUR  = 10'd12;
  localparam logic [6:0]         ID_PAGE  = 7'h7F;

  localparam logic [STAT_W-1:0] TICK_SET = STAT_W'((1 << ST_NEXT_BASE) | (1 << ST_VCOMP));

  function automatic logic [7:0] id_byte(input logic ext, input logic [2:0] idx);
    logic [7:0] b;
    case (idx)
      3'd0:    b = ext ? 8'h11 : 8'h10;
      3'd1:    b = 8'h11;
      3'd2:    b = ext ? 8'h24 : 8'h04;
      3'd3:    b = 8'h00;
      3'd4:    b = 8'h0D;
      3'd5:    b = 8'hF0;
      3'd6:    b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/lcd_frame_tick.sv
module lcd_frame_tick #(
  parameter int TICK_CYCLES = 833_333
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int CNT_W = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic wrap;

  assign wrap   = (cnt_q == LAST);
  assign tick_o = en_i && !restart_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (!en_i || restart_i)   cnt_q <= '0;
    else if (wrap)                 cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  p_idle_when_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0);
  p_restart_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> cnt_q == '0);
endmodule

// File: rtl/lcd_irq_unit.sv
module lcd_irq_unit
  import lcd_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mask_we_i,
  input  logic [STAT_W-1:0] mask_d_i,
  input  logic              clr_we_i,
  input  logic [STAT_W-1:0] clr_d_i,
  input  logic [STAT_W-1:0] set_i,
  output logic [STAT_W-1:0] raw_o,
  output logic [STAT_W-1:0] mask_o,
  output logic              irq_o
);
  logic [STAT_W-1:0] raw_q, mask_q, clr_vec;

  assign clr_vec = clr_we_i ? clr_d_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= (raw_q & ~clr_vec) | set_i;  // set wins over clear
      if (mask_we_i) mask_q <= mask_d_i;
    end
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign irq_o  = |(raw_q & mask_q);

  p_clear_takes_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && set_i == '0) |=> (raw_q & $past(clr_d_i)) == '0);
  p_set_beats_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> (raw_q & $past(set_i)) == $past(set_i));
  p_rise_needs_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0) |=> (raw_q & ~$past(raw_q)) == '0);
  p_mask_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> mask_q == $past(mask_d_i));
endmodule

// File: rtl/lcd_geom_decode.sv
module lcd_geom_decode
  import lcd_reg_pkg::*;
(
  input  logic [5:0]       hfield_i,
  input  logic [9:0]       vfield_i,
  output logic [COL_W-1:0] cols_o,
  output logic [ROW_W-1:0] rows_o
);
  // ((t0 & 0xFC) + 4) * 4 == (t0[7:2] + 1) * 16
  assign cols_o = (COL_W'(hfield_i) + COL_W'(1)) << 4;
  assign rows_o = ROW_W'(vfield_i) + ROW_W'(1);
endmodule

// File: rtl/lcd_reg_irq.sv
module lcd_reg_irq
  import lcd_reg_pkg::*;
#(
  parameter int TICK_CYCLES = 833_333
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         variant_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [WORD_AW-1:0] word_addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o,
  output logic               invalidate_o,
  output logic               enabled_o,
  output logic [BPP_W-1:0]   bpp_o,
  output logic [COL_W-1:0]   cols_o,
  output logic [ROW_W-1:0]   rows_o
);
  logic swap, ext_id, id_hit;
  logic wr_ctrl, wr_mask, wr_clr, restart, tick;
  logic [DATA_W-1:0] timing_w [NUM_TIMING];
  logic [DATA_W-1:0] upbase_q, lpbase_q, ctrl_q, rd_val, rdata_q;
  logic [STAT_W-1:0] raw, mask;
  logic inval_q;

  assign swap    = (variant_i != 2'd0);
  assign ext_id  = variant_i[1];
  assign id_hit  = (word_addr_i[WORD_AW-1:3] == ID_PAGE);
  assign wr_ctrl = wr_i && (word_addr_i == (swap ? W_SLOT_A : W_SLOT_B));
  assign wr_mask = wr_i && (word_addr_i == (swap ? W_SLOT_B : W_SLOT_A));
  assign wr_clr  = wr_i && (word_addr_i == W_CLEAR);
  assign restart = wr_ctrl && wdata_i[CTRL_EN_BIT] && wdata_i[CTRL_PWR_BIT];

  for (genvar g = 0; g < NUM_TIMING; g++) begin : g_timing
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       q <= '0;
      else if (wr_i && word_addr_i == WORD_AW'(g))       q <= wdata_i;
    end
    assign timing_w[g] = q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upbase_q <= '0;
      lpbase_q <= '0;
      ctrl_q   <= '0;
      inval_q  <= 1'b0;
    end else begin
      if (wr_i && word_addr_i == W_UPBASE) upbase_q <= wdata_i;
      if (wr_i && word_addr_i == W_LPBASE) lpbase_q <= wdata_i;
      if (wr_ctrl)                         ctrl_q   <= wdata_i;
      inval_q <= wr_i;
    end
  end

  assign enabled_o    = ctrl_q[CTRL_EN_BIT] & ctrl_q[CTRL_PWR_BIT];
  assign bpp_o        = ctrl_q[BPP_W:1];
  assign invalidate_o = inval_q;

  lcd_frame_tick #(.TICK_CYCLES(TICK_CYCLES)) i_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (enabled_o),
    .restart_i(restart),
    .tick_o   (tick)
  );

  lcd_irq_unit i_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mask_we_i(wr_mask),
    .mask_d_i (wdata_i[STAT_W-1:0]),
    .clr_we_i (wr_clr),
    .clr_d_i  (wdata_i[STAT_W-1:0]),
    .set_i    (tick ? TICK_SET : '0),
    .raw_o    (raw),
    .mask_o   (mask),
    .irq_o    (irq_o)
  );

  lcd_geom_decode i_geom (
    .hfield_i(timing_w[0][7:2]),
    .vfield_i(timing_w[1][9:0]),
    .cols_o  (cols_o),
    .rows_o  (rows_o)
  );

  always_comb begin
    rd_val = '0;
    if (id_hit) begin
      rd_val = DATA_W'(id_byte(ext_id, word_addr_i[2:0]));
    end else if (word_addr_i < WORD_AW'(NUM_TIMING)) begin
      rd_val = timing_w[word_addr_i[1:0]];
    end else begin
      case (word_addr_i)
        W_UPBASE, W_UPCUR: rd_val = upbase_q;
        W_LPBASE, W_LPCUR: rd_val = lpbase_q;
        W_SLOT_A:          rd_val = swap ? ctrl_q : DATA_W'(mask);
        W_SLOT_B:          rd_val = swap ? DATA_W'(mask) : ctrl_q;
        W_RAW:             rd_val = DATA_W'(raw);
        W_MSK_ST:          rd_val = DATA_W'(raw & mask);
        default:           rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_val;
  end
  assign rdata_o = rdata_q;

  p_inval_after_wr_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> invalidate_o);
  p_inval_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> !invalidate_o);
  p_rdata_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
  p_swap_ctrl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && variant_i != 2'd0 && word_addr_i == W_SLOT_A)
      |=> enabled_o == ($past(wdata_i[CTRL_EN_BIT]) && $past(wdata_i[CTRL_PWR_BIT])));
  p_undef_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && word_addr_i == 10'd13) |=> rdata_o == '0);
  p_no_tick_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enabled_o |=> (raw & ~$past(raw)) == '0);
endmodule

// File: tb/test_lcd_reg_irq.sv
`timescale 1ns/1ps
module test_lcd_reg_irq;
  localparam int P = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  variant = 2'd0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [9:0]  wa = '0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic        irq, inval, en;
  logic [2:0]  bpp;
  logic [10:0] cols, rows;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic inval_seen;
  logic [31:0] r;

  always #2.5 clk = ~clk;

  lcd_reg_irq #(.TICK_CYCLES(P)) i_lcd_reg_irq (
    .clk_i(clk), .rst_ni(rst_n), .variant_i(variant), .wr_i(wr), .rd_i(rd),
    .word_addr_i(wa), .wdata_i(wd), .rdata_o(rdata), .irq_o(irq),
    .invalidate_o(inval), .enabled_o(en), .bpp_o(bpp), .cols_o(cols), .rows_o(rows)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    wa = a[11:2]; wd = d; wr = 1'b1;
    @(posedge clk); @(negedge clk);
    wr = 1'b0; inval_seen = inval;
  endtask

  task automatic rd_reg(input logic [11:0] a, output logic [31:0] d);
    wa = a[11:2]; rd = 1'b1;
    @(posedge clk); @(negedge clk);
    rd = 1'b0; d = rdata;
  endtask

  function automatic logic [7:0] exp_id(input int v, input int k);
    logic [7:0] tail [4] = '{8'h0D, 8'hF0, 8'h05, 8'hB1};
    if (k >= 4) return tail[k-4];
    if (k == 1) return 8'h11;
    if (k == 3) return 8'h00;
    if (k == 0) return (v >= 2) ? 8'h11 : 8'h10;
    return (v >= 2) ? 8'h24 : 8'h04;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 irq", 32'(irq), 0); check("R1 inval", 32'(inval), 0);
    check("R1 en", 32'(en), 0); check("R1 cols", 32'(cols), 16); check("R1 rows", 32'(rows), 1);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a <= 'h30; a += 4) begin
      rd_reg(12'(a), r); check("R1 reg zero", r, 0);
    end
    check("R1 bpp", 32'(bpp), 0);

    // R2 base layout
    for (int t = 0; t < 4; t++) wr_reg(12'(t*4), 32'hC0DE_0000 + 32'(t * 32'h1111));
    wr_reg(12'h010, 32'h8000_1000); wr_reg(12'h014, 32'h8040_2000);
    wr_reg(12'h018, 32'hFFFF_FFF5); wr_reg(12'h01C, 32'h1234_5670);
    for (int t = 0; t < 4; t++) begin
      rd_reg(12'(t*4), r); check("R2 timing", r, 32'hC0DE_0000 + 32'(t * 32'h1111));
    end
    rd_reg(12'h010, r); check("R2 upper", r, 32'h8000_1000);
    rd_reg(12'h014, r); check("R2 lower", r, 32'h8040_2000);
    rd_reg(12'h018, r); check("R2 mask", r, 32'h5);
    rd_reg(12'h01C, r); check("R2 ctrl", r, 32'h1234_5670);
    repeat (3) @(negedge clk);
    check("R2 rdata hold", rdata, 32'h1234_5670);

    // R10 current addresses
    rd_reg(12'h02C, r); check("R10 upper cur", r, 32'h8000_1000);
    rd_reg(12'h030, r); check("R10 lower cur", r, 32'h8040_2000);

    // R12 invalidate pulse
    wr_reg(12'h008, 32'h55); check("R12 pulse high", 32'(inval_seen), 1);
    @(negedge clk); check("R12 pulse low", 32'(inval), 0);
    rd_reg(12'h008, r); check("R12 no pulse on read", 32'(inval), 0);

    // R4 column sweep
    for (int v = 0; v < 64; v++) begin
      logic [31:0] d;
      d = {24'hA5_5A_3C ^ 24'(v), 6'(v), 2'b11};
      wr_reg(12'h000, d);
      check("R4 cols", 32'(cols), ((d & 32'hFC) + 4) * 4);
    end
    // R4 row sweep
    for (int v = 0; v < 1024; v++) begin
      logic [31:0] d;
      d = (32'(v) * 32'h9E37) << 10 | 32'(v);
      wr_reg(12'h004, d);
      check("R4 rows", 32'(rows), (d & 32'h3FF) + 1);
    end

    // R5 enable and depth
    for (int e = 0; e < 2; e++)
      for (int p = 0; p < 2; p++)
        for (int b = 0; b < 8; b++) begin
          wr_reg(12'h01C, 32'(e) | (32'(p) << 11) | (32'(b) << 1) | 32'h0000_5020);
          check("R5 enabled", 32'(en), 32'(e & p));
          check("R5 bpp", 32'(bpp), 32'(b));
        end

    // R6 tick timing
    wr_reg(12'h01C, 0); wr_reg(12'h028, 32'hF);
    rd_reg(12'h020, r); check("R6 raw cleared", r, 0);
    wr_reg(12'h018, 32'hC);
    wr_reg(12'h01C, 32'h801);
    repeat (P-1) @(negedge clk); check("R6 before tick", 32'(irq), 0);
    @(negedge clk);              check("R6 at tick", 32'(irq), 1);
    rd_reg(12'h020, r);          check("R6 raw bits", r, 32'hC);
    wr_reg(12'h028, 32'hC);      check("R7 clear irq", 32'(irq), 0);
    repeat (10) @(negedge clk);
    wr_reg(12'h01C, 32'h803);    // restart
    repeat (P-1) @(negedge clk); check("R6 restart before", 32'(irq), 0);
    @(negedge clk);              check("R6 restart at", 32'(irq), 1);
    wr_reg(12'h028, 32'hF);
    repeat (P-2) @(negedge clk); check("R6 period before", 32'(irq), 0);
    @(negedge clk);              check("R6 period at", 32'(irq), 1);
    // R7 tick on the clear edge
    repeat (P-1) @(negedge clk);
    wr_reg(12'h028, 32'hC);
    rd_reg(12'h020, r);          check("R7 set wins", r, 32'hC);
    wr_reg(12'h028, 32'h4);
    rd_reg(12'h020, r);          check("R7 partial clear", r, 32'h8);
    // R6 disabled: no ticks
    wr_reg(12'h01C, 32'h001); wr_reg(12'h028, 32'hF);
    repeat (3*P) @(negedge clk);
    check("R6 off irq", 32'(irq), 0);
    rd_reg(12'h020, r);          check("R6 off raw", r, 0);
    wr_reg(12'h01C, 32'h800);
    repeat (2*P) @(negedge clk);
    rd_reg(12'h020, r);          check("R6 power only raw", r, 0);

    // R8 mask sweep with raw = 0xC
    wr_reg(12'h01C, 32'h801);
    repeat (P) @(negedge clk);
    wr_reg(12'h01C, 0);
    rd_reg(12'h020, r);          check("R8 raw setup", r, 32'hC);
    for (int m = 0; m < 16; m++) begin
      wr_reg(12'h018, 32'hFFFF_FFF0 | 32'(m));
      rd_reg(12'h018, r); check("R8 mask read", r, 32'(m));
      rd_reg(12'h024, r); check("R8 masked", r, 32'hC & 32'(m));
      check("R8 irq", 32'(irq), 32'((m & 'hC) != 0));
    end

    // R11 ignored writes, zero reads
    wr_reg(12'h020, 0); wr_reg(12'h024, 32'hFFFF_FFFF);
    rd_reg(12'h020, r);          check("R11 raw unchanged", r, 32'hC);
    wr_reg(12'h034, 32'hDEAD_BEEF); wr_reg(12'h200, 32'hDEAD_BEEF); wr_reg(12'hFDC, 32'hFFFF_FFFF);
    rd_reg(12'h008, r);          check("R11 timing2 kept", r, 32'h55);
    rd_reg(12'h010, r);          check("R11 upper kept", r, 32'h8000_1000);
    rd_reg(12'h01C, r);          check("R11 ctrl kept", r, 0);
    rd_reg(12'h018, r);          check("R11 mask kept", r, 32'hF);
    foreach (r[i]) begin end
    rd_reg(12'h034, r);          check("R11 undef 0x034", r, 0);
    rd_reg(12'h200, r);          check("R11 undef 0x200", r, 0);
    rd_reg(12'h800, r);          check("R11 undef 0x800", r, 0);
    rd_reg(12'hFDC, r);          check("R11 undef 0xFDC", r, 0);

    // R3 swapped layout
    for (int v = 1; v < 3; v++) begin
      variant = 2'(v);
      @(negedge clk);
      wr_reg(12'h018, 32'h80F);
      check("R3 ctrl at 0x18 en", 32'(en), 1);
      check("R3 ctrl at 0x18 bpp", 32'(bpp), 7);
      wr_reg(12'h01C, 32'(v));
      rd_reg(12'h01C, r);        check("R3 mask at 0x1C", r, 32'(v));
      rd_reg(12'h018, r);        check("R3 ctrl read", r, 32'h80F);
      wr_reg(12'h018, 0);
      check("R3 ctrl off", 32'(en), 0);
    end

    // R9 identification bytes
    for (int v = 0; v < 4; v++) begin
      variant = 2'(v);
      @(negedge clk);
      for (int k = 0; k < 8; k++) begin
        rd_reg(12'hFE0 + 12'(k*4), r);
        check("R9 id byte", r, 32'(exp_id(v, k)));
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule